// File: doc/BRIEF.md
# Link PHY Test Pattern Generator

This block sits between a display link's symbol encoder and its serialiser and supplies four lanes of 10-bit symbols, one symbol per lane on every clock. In normal operation it forwards the encoder's symbols unchanged, one register stage late. When the test override is switched on it replaces them with a compliance pattern. Each lane takes either a looping bank of eight programmable 10-bit symbols or the output of a pseudo-random engine. The engine runs either a 7-bit sequence or a longer 15-bit sequence that is used for symbol-error measurement.

A small write-only register port programs the block. The control word holds the override, the engine enable and sequence choice, and one pattern-source bit per lane. Three symbol words fill the symbol bank, and a training word selects one of four link-training patterns for the upstream encoder. The mode is held by a three-state machine. ST_LIVE forwards encoder symbols. ST_TRAIN forwards encoder symbols and also presents a training index. ST_TEST drives the test pattern.

The transitions are as follows:
- ST_LIVE → ST_TEST on a control write with the override bit set.
- ST_LIVE → ST_TRAIN on a training write.
- ST_TRAIN → ST_TEST or ST_LIVE on any control write, chosen by its override bit.
- ST_TRAIN → ST_TRAIN on a further training write.
- ST_TEST → ST_LIVE on a control write with the override bit clear.

While ST_TEST is active the configuration is frozen, so a half-written pattern can never reach the lanes.

Top module: `ptg_top`

## Requirements
- R1: While reset is asserted, and on leaving it, `lanes_out` is zero, `train_act` is 0 and `train_idx` is 0.
- R2: When the override is off, `lanes_out` equals the `link_sym_in` value sampled at the previous rising edge. Lane k occupies bits [10k+9:10k].
- R3: A control write (address 0) with bit 0 set enters the test mode on the write edge. From the next edge on, every lane whose source bit (control bit 4+k for lane k) is 1 emits stored symbols 0,1,…,7,0,… with one symbol per clock. Symbol 0 comes first, and all such lanes are aligned.
- R4: Symbol j is bits [10j+9:10j] of an 80-bit pattern, so a ten-byte pattern packs little-endian with byte 0 at the bottom. Symbols 0–2 are written at address 2, symbols 3–5 at address 3, and symbols 6–7 at address 4, each in data fields [9:0], [19:10] and [29:20].
- R5: A lane whose source bit is 0, with the engine enabled (control bit 1) and sequence bit (control bit 2) at 0, emits the x^7+x^6+1 sequence. The state starts at all ones on entry to the test mode. Each new bit is state[6]^state[5] and is shifted in at the bottom. Ten bits are produced per clock, and the first one lands in symbol bit 0.
- R6: With the sequence bit at 1, the same lanes use x^15+x^14+1 (new bit state[14]^state[13]), under the same seeding and bit order.
- R7: A lane whose source bit is 0 while the engine is disabled emits 0. Loading all eight symbols with 0x2AA yields the D10.2 clock pattern on lanes whose source bit is 1.
- R8: While in test mode, symbol and training writes are ignored. A control write there changes only the override bit.
- R9: Outside test mode, a training write (address 1) stores data[1:0] in `train_idx`, raises `train_act` on the write edge and turns the engine enable off. The next control write drops `train_act`.
- R10: Lane sources are independent: in one test run, lanes set to symbols and lanes set to the engine each follow their own rule at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| link_sym_in | input | 40 | Encoded link symbols, four lanes of 10 bits |
| lanes_out | output | 40 | Symbols to the serialiser, four lanes of 10 bits |
| train_idx | output | 2 | Selected training pattern index (0–3 for patterns 1–4) |
| train_act | output | 1 | Training-pattern mode is active |

## Verification
The forwarding path is driven with a ramp of distinct per-lane words, which exposes a wrong latency or a lane swap. The symbol bank is loaded from a ten-byte pattern with irregular byte values, so a misplaced field or a broken byte packing shows up as a wrong symbol at a known position. Both pseudo-random sequences are compared against arithmetic models over many clocks, which separates the polynomials, the seed and the bit order. Mixed lane-source masks, an all-0x2AA bank, a disabled engine and writes issued during test mode separate per-lane selection, the zero fill and the configuration lock. All four training indices are swept.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        ST_LIVE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_TEST  = 2'd2
    } ptg_state_e;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_TRAIN = 1;
    localparam int ADDR_SYM0  = 2;

    localparam int CB_BYPASS  = 0;
    localparam int CB_PRBS_EN = 1;
    localparam int CB_PRBS_SL = 2;
    localparam int CB_LANE0   = 4;

    localparam int TRAIN_W    = 2;

endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SYM_W  = 10,
    parameter int NSYM   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    test_o,
    output logic                    train_act_o,
    output logic [TRAIN_W-1:0]      train_idx_o,
    output logic                    prbs_en_o,
    output logic                    prbs_sel_o,
    output logic [LANES-1:0]        lane_sel_o,
    output logic [NSYM*SYM_W-1:0]   syms_o
);
    localparam int PER_REG = DATA_W / SYM_W;
    localparam int NREG    = (NSYM + PER_REG - 1) / PER_REG;

    ptg_state_e state_q, state_d;

    logic                   prbs_en_q;
    logic                   prbs_sel_q;
    logic [LANES-1:0]       lane_sel_q;
    logic [TRAIN_W-1:0]     train_idx_q;
    logic [SYM_W-1:0]       sym_q [NSYM];

    logic ctrl_wr;
    logic train_wr;
    logic cfg_open;

    assign ctrl_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
    assign train_wr = wr_en && (wr_addr == ADDR_W'(ADDR_TRAIN));
    assign cfg_open = (state_q != ST_TEST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LIVE: begin
                if (ctrl_wr && wr_data[CB_BYPASS])
                    state_d = ST_TEST;
                else if (train_wr)
                    state_d = ST_TRAIN;
            end
            ST_TRAIN: begin
                if (ctrl_wr)
                    state_d = wr_data[CB_BYPASS] ? ST_TEST : ST_LIVE;
            end
            ST_TEST: begin
                if (ctrl_wr && !wr_data[CB_BYPASS])
                    state_d = ST_LIVE;
            end
            default: state_d = ST_LIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_LIVE;
        else
            state_q <= state_d;
    end

    // configuration fields, writable only outside test mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prbs_en_q   <= 1'b0;
            prbs_sel_q  <= 1'b0;
            lane_sel_q  <= '0;
            train_idx_q <= '0;
        end else if (cfg_open) begin
            if (ctrl_wr) begin
                prbs_en_q  <= wr_data[CB_PRBS_EN];
                prbs_sel_q <= wr_data[CB_PRBS_SL];
                lane_sel_q <= wr_data[CB_LANE0 +: LANES];
            end else if (train_wr) begin
                train_idx_q <= wr_data[TRAIN_W-1:0];
                prbs_en_q   <= 1'b0;
            end
        end
    end

    // symbol bank: one register per symbol, grouped PER_REG to an address
    for (genvar r = 0; r < NREG; r++) begin : g_word
        for (genvar f = 0; f < PER_REG; f++) begin : g_field
            if (r * PER_REG + f < NSYM) begin : g_sym
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        sym_q[r*PER_REG+f] <= '0;
                    else if (cfg_open && wr_en &&
                             wr_addr == ADDR_W'(ADDR_SYM0 + r))
                        sym_q[r*PER_REG+f] <= wr_data[f*SYM_W +: SYM_W];
                end
            end
        end
    end

    for (genvar j = 0; j < NSYM; j++) begin : g_flat
        assign syms_o[j*SYM_W +: SYM_W] = sym_q[j];
    end

    if (PER_REG * SYM_W < DATA_W) begin : g_spare
        logic unused_hi;
        assign unused_hi = ^wr_data[DATA_W-1:PER_REG*SYM_W];
    end

    // output process
    always_comb begin
        test_o      = 1'b0;
        train_act_o = 1'b0;
        unique case (state_q)
            ST_LIVE:  ;
            ST_TRAIN: train_act_o = 1'b1;
            ST_TEST:  test_o      = 1'b1;
            default:  ;
        endcase
    end

    assign train_idx_o = train_idx_q;
    assign prbs_en_o   = prbs_en_q;
    assign prbs_sel_o  = prbs_sel_q;
    assign lane_sel_o  = lane_sel_q;

    AST_TRAIN_PRBS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIN) |-> !prbs_en_q); // R9

    AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && $past(state_q) == ST_TEST) |-> $stable(syms_o)); // R8

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TEST && $past(state_q) == ST_TEST) |-> $stable(lane_sel_q)); // R8

    AST_TEST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state_q) != ST_TEST && state_q == ST_TEST)
        |-> $past(wr_en && wr_addr == ADDR_W'(ADDR_CTRL) && wr_data[CB_BYPASS])); // R3

endmodule

// File: rtl/ptg_lfsr.sv
module ptg_lfsr #(
    parameter int LEN   = 7,
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [SYM_W-1:0] word_o
);
    localparam logic [LEN-1:0] SEED = '1;

    logic [LEN-1:0] st_q;
    logic [LEN-1:0] st_n;

    // produce SYM_W serial bits per clock, first bit into bit 0
    always_comb begin
        logic [LEN-1:0] t;
        logic           nb;
        t      = st_q;
        word_o = '0;
        for (int i = 0; i < SYM_W; i++) begin
            nb        = t[LEN-1] ^ t[LEN-2];
            word_o[i] = nb;
            t         = {t[LEN-2:0], nb};
        end
        st_n = t;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            st_q <= SEED;
        else
            st_q <= st_n;
    end

    AST_SEED_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(run)) |-> (st_q == SEED)); // R5

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0); // R6

endmodule

// File: rtl/ptg_seq.sv
module ptg_seq #(
    parameter int LANES = 4,
    parameter int SYM_W = 10,
    parameter int NSYM  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   active,
    input  logic                   prbs_en,
    input  logic                   prbs_sel,
    input  logic [LANES-1:0]       lane_sel,
    input  logic [NSYM*SYM_W-1:0]  syms,
    input  logic [SYM_W-1:0]       w_short,
    input  logic [SYM_W-1:0]       w_long,
    output logic [LANES*SYM_W-1:0] pat_o
);
    localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYM - 1);

    logic [IDX_W-1:0] idx_q;
    logic [SYM_W-1:0] cur_sym;
    logic [SYM_W-1:0] rnd_word;

    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            idx_q <= '0;
        else if (idx_q == LAST)
            idx_q <= '0;
        else
            idx_q <= idx_q + 1'b1;
    end

    assign cur_sym  = syms[idx_q*SYM_W +: SYM_W];
    assign rnd_word = !prbs_en ? '0 : (prbs_sel ? w_long : w_short);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign pat_o[k*SYM_W +: SYM_W] = lane_sel[k] ? cur_sym : rnd_word;
    end

    AST_IDX_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(active)) |-> (idx_q == '0)); // R3

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && $past(idx_q) == LAST) |-> (idx_q == '0)); // R3

endmodule

// File: rtl/ptg_top.sv
module ptg_top
    import ptg_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SYM_W  = 10,
    parameter int NSYM   = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int SHORT_LEN = 7,
    parameter int LONG_LEN  = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [LANES*SYM_W-1:0]  link_sym_in,
    output logic [LANES*SYM_W-1:0]  lanes_out,
    output logic [TRAIN_W-1:0]      train_idx,
    output logic                    train_act
);
    localparam int LW = LANES * SYM_W;

    logic                  test;
    logic                  prbs_en;
    logic                  prbs_sel;
    logic [LANES-1:0]      lane_sel;
    logic [NSYM*SYM_W-1:0] syms;
    logic [SYM_W-1:0]      prbs_w [2];
    logic [LW-1:0]         pat;
    logic                  run;

    ptg_regs #(
        .LANES(LANES), .SYM_W(SYM_W), .NSYM(NSYM),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .test_o(test), .train_act_o(train_act), .train_idx_o(train_idx),
        .prbs_en_o(prbs_en), .prbs_sel_o(prbs_sel),
        .lane_sel_o(lane_sel), .syms_o(syms)
    );

    assign run = test && prbs_en;

    for (genvar g = 0; g < 2; g++) begin : g_prbs
        localparam int LEN = (g == 0) ? SHORT_LEN : LONG_LEN;
        ptg_lfsr #(.LEN(LEN), .SYM_W(SYM_W)) u_lfsr (
            .clk(clk), .rst_n(rst_n), .run(run), .word_o(prbs_w[g])
        );
    end

    ptg_seq #(.LANES(LANES), .SYM_W(SYM_W), .NSYM(NSYM)) u_seq (
        .clk(clk), .rst_n(rst_n), .active(test),
        .prbs_en(prbs_en), .prbs_sel(prbs_sel), .lane_sel(lane_sel),
        .syms(syms), .w_short(prbs_w[0]), .w_long(prbs_w[1]),
        .pat_o(pat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            lanes_out <= '0;
        else if (test)
            lanes_out <= pat;
        else
            lanes_out <= link_sym_in;
    end

    AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(test)) |-> (lanes_out == $past(link_sym_in))); // R2

    AST_TRAIN_NOT_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        !(train_act && test)); // R9

endmodule

// File: tb/tb_ptg_top.sv
module tb_ptg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [39:0] link_sym_in = '0;
    logic [39:0] lanes_out;
    logic [1:0]  train_idx;
    logic        train_act;

    int n_vec = 0;
    int n_bad = 0;

    logic [9:0]  syms [8];
    logic [79:0] pat80;

    always #2 clk = ~clk;

    ptg_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .link_sym_in(link_sym_in),
        .lanes_out(lanes_out), .train_idx(train_idx), .train_act(train_act)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [39:0] act, input logic [39:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [24:0] prbs_m(input logic [14:0] s, input int len);
        logic [9:0]  w;
        logic [14:0] mask;
        logic        nb;
        mask = 15'((1 << len) - 1);
        for (int i = 0; i < 10; i++) begin
            nb   = s[len-1] ^ s[len-2];
            w[i] = nb;
            s    = ((s << 1) | 15'(nb)) & mask;
        end
        return {s, w};
    endfunction

    function automatic logic [31:0] ctrl(input bit byp, input bit pen,
                                         input bit psel, input logic [3:0] ls);
        return {24'd0, ls, 1'b0, psel, pen, byp};
    endfunction

    task automatic load_syms();
        for (int r = 0; r < 3; r++) begin
            logic [31:0] d;
            d = '0;
            for (int f = 0; f < 3; f++)
                if (r*3 + f < 8) d[f*10 +: 10] = syms[r*3+f];
            wr(2 + r, d);
        end
    endtask

    // after the entry write returns, check n cycles of the test pattern
    task automatic run_pat(input int n, input logic [3:0] ls, input bit pen,
                           input bit psel, input string req);
        logic [14:0] s7, s15;
        logic [24:0] r7, r15;
        logic [39:0] exp;
        s7 = 15'h7f; s15 = 15'h7fff;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            r7  = prbs_m(s7, 7);
            r15 = prbs_m(s15, 15);
            for (int k = 0; k < 4; k++) begin
                if (ls[k])      exp[k*10 +: 10] = syms[c % 8];
                else if (!pen)  exp[k*10 +: 10] = '0;
                else            exp[k*10 +: 10] = psel ? r15[9:0] : r7[9:0];
            end
            chk(lanes_out == exp, req, lanes_out, exp);
            s7 = r7[24:10]; s15 = r15[24:10];
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(lanes_out == '0 && !train_act && train_idx == 0, "R1",
            {lanes_out[37:0], train_idx}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lanes_out == '0 && !train_act && train_idx == 0, "R1",
            {lanes_out[37:0], train_idx}, '0);

        // R2 passthrough with a per-lane ramp
        for (int i = 0; i < 24; i++) begin
            logic [39:0] v;
            v = {10'(i*7+3), 10'(i*13+100), 10'(1023-i*5), 10'(i*29+511)};
            link_sym_in = v;
            @(negedge clk);
            chk(lanes_out == v, "R2", lanes_out, v);
        end

        // R4 build bank from ten bytes, little-endian
        for (int b = 0; b < 10; b++) pat80[b*8 +: 8] = 8'((b*53 + 17) & 255);
        for (int j = 0; j < 8; j++) syms[j] = pat80[j*10 +: 10];
        load_syms();

        // R3 / R4 all lanes on symbols
        wr(0, ctrl(1, 0, 0, 4'b1111));
        run_pat(20, 4'b1111, 0, 0, "R3_R4");

        // R8 writes during test mode are ignored
        wr(2, 32'h3fff_ffff);
        wr(4, 32'h0000_1234);
        wr(1, 32'd3);
        @(negedge clk);
        chk(!train_act && train_idx == 0, "R8", {38'd0, train_idx}, '0);
        wr(0, ctrl(0, 0, 0, 4'b0000));
        wr(0, ctrl(1, 0, 0, 4'b1111));
        run_pat(16, 4'b1111, 0, 0, "R8");
        // control write during test: only override honoured, lanes unchanged
        wr(0, ctrl(1, 1, 1, 4'b0000));
        wr(0, ctrl(0, 0, 0, 4'b0000));
        link_sym_in = 40'h12345_6789a;
        @(negedge clk);
        chk(lanes_out == 40'h12345_6789a, "R8", lanes_out, 40'h12345_6789a);

        // R5 short sequence on all lanes
        wr(0, ctrl(1, 1, 0, 4'b0000));
        run_pat(40, 4'b0000, 1, 0, "R5");
        wr(0, 32'd0);
        // R6 long sequence
        wr(0, ctrl(1, 1, 1, 4'b0000));
        run_pat(60, 4'b0000, 1, 1, "R6");
        wr(0, 32'd0);

        // R10 mixed lane masks, both sequences
        for (int m = 1; m < 15; m++) begin
            wr(0, ctrl(1, 1, m[0], 4'(m)));
            run_pat(10, 4'(m), 1, m[0], "R10");
            wr(0, 32'd0);
        end

        // R7 engine disabled, and D10.2 pattern
        wr(0, ctrl(1, 0, 0, 4'b0011));
        run_pat(10, 4'b0011, 0, 0, "R7");
        wr(0, 32'd0);
        for (int j = 0; j < 8; j++) syms[j] = 10'h2aa;
        load_syms();
        wr(0, ctrl(1, 0, 0, 4'b1111));
        run_pat(12, 4'b1111, 0, 0, "R7");
        wr(0, 32'd0);

        // R9 training indices, passthrough kept, exit on control write
        for (int t = 0; t < 4; t++) begin
            wr(1, 32'(t));
            chk(train_act && train_idx == 2'(t), "R9",
                {37'd0, train_act, train_idx}, {37'd0, 1'b1, 2'(t)});
            link_sym_in = 40'(t * 40'h01_0040_1003);
            @(negedge clk);
            chk(lanes_out == link_sym_in, "R9", lanes_out, link_sym_in);
        end
        wr(0, 32'd0);
        chk(!train_act, "R9", {39'd0, train_act}, '0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule